// File: doc/BRIEF.md
# Four-Byte Group ECC Memory Wrapper

This block sits between a byte-wide host port and a word-wide storage array. The array holds one 39-bit codeword per aligned group of four bytes: 32 data bits and 7 check bits of a single-error-correct, double-error-detect Hamming code. The host only issues plain byte reads and byte writes. The error protection and the whole-group accesses it forces are invisible to the host, except for two status flags.

A byte read fetches the group's codeword and repairs any single flipped bit. It then returns the addressed byte. A byte write fetches the group the same way and corrects it. The new byte is merged into its lane, fresh check bits are computed and the whole group is written back. So a write always rewrites the three neighbour bytes, and it scrubs a latent single-bit error in them.

Because wear happens per group, the block keeps a saturating write counter for each group. The counter steps once per group rewrite, whichever byte lane the host targeted. Each write completion reports the group's updated count. A small sequencer runs each access. While it runs, a busy output is held high and new requests are dropped.

Top module: `grp_ecc_mem`

## Requirements
- R1: While rst is high and in the cycle after it is released, busy, rd_valid, wr_done, err_corr, err_uncorr, arr_rd_en and arr_wr_en are all 0.
- R2: A read accepted at clock edge k (req_valid=1, req_we=0, busy=0) raises rd_valid for exactly one cycle after edge k+2. rd_data then holds the byte at req_addr. Byte lane req_addr[1:0] maps to data bits [8*lane+7:8*lane] of the group at word index req_addr[AW-1:2].
- R3: A write changes only the addressed byte. The other three bytes of its group keep their values, and the whole group is written to the array as one word at index req_addr[AW-1:2].
- R4: If exactly one bit of a group's 39-bit stored codeword is flipped, the read still returns the correct byte and err_corr becomes 1. err_corr stays 1 until reset.
- R5: If two bits of a group's codeword are flipped, the access sets err_uncorr to 1. err_uncorr stays 1 until reset, including across later error-free accesses.
- R6: busy goes high in the cycle after a request is accepted and falls in the same cycle as that request's single rd_valid or wr_done pulse. Any request presented while busy is high has no effect on the array or on the outputs.
- R7: Each group has its own saturating write counter of CNT_W bits. Only writes increment it, by one per write, and it stops at 2**CNT_W-1. With wr_done, wr_cnt shows the group's count after that write.
- R8: A write into a group that holds one flipped bit stores the corrected neighbour bytes. A single further flip in that group is then still corrected, and err_uncorr is not set.
- R9: Every access issues exactly one array read. A write adds exactly one array write in the cycle after the read data is checked. arr_rd_en and arr_wr_en are never high together, and arr_rdata is expected one cycle after arr_rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe, sampled when busy is low |
| req_we | input | 1 | 1 for byte write, 0 for byte read |
| req_addr | input | AW | Byte address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Access in progress; requests are dropped |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 8 | Read byte |
| wr_done | output | 1 | One-cycle write completion strobe |
| wr_cnt | output | CNT_W | Updated write count of the written group |
| err_corr | output | 1 | Sticky single-bit error corrected |
| err_uncorr | output | 1 | Sticky uncorrectable error seen |
| arr_rd_en | output | 1 | Array word read enable |
| arr_wr_en | output | 1 | Array word write enable |
| arr_addr | output | AW-2 | Array word (group) index |
| arr_wdata | output | 39 | Codeword to store |
| arr_rdata | input | 39 | Codeword read, valid one cycle after arr_rd_en |

## Verification
The bench writes single lanes and then reads the three neighbours back. A design that merged into the wrong lane, or wrote only one byte, would return stale or zeroed neighbours. It flips single codeword bits in the overall-parity bit, a check bit, and data positions at both ends. A design with a wrong syndrome map would return a corrupted byte, or would flag these flips as uncorrectable.

A scrub case places one flip, writes the group, and then adds a second flip. A design that wrote back the uncorrected data would now report a double error. Counter saturation, reads leaving the count unchanged, and a request slipped in while busy round out the set. A design that wrapped the counter, counted reads, or accepted the slipped request would show a wrong wr_cnt or an unexpected result pulse.

// File: rtl/grp_ecc_pkg.sv
package grp_ecc_pkg;
  localparam int DW     = 32;
  localparam int PW     = 6;
  localparam int CW     = 39;
  localparam int MAXPOS = 38;

  typedef logic [CW-1:0] cw_t;
  typedef logic [DW-1:0] dword_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CHECK} st_t;

  // Hamming positions that are powers of two hold check bits
  function automatic logic is_chk_pos(int i);
    return (i & (i - 1)) == 0;
  endfunction

  function automatic cw_t place_data(dword_t d);
    cw_t c = '0;
    int  k = 0;
    for (int i = 1; i <= MAXPOS; i++) begin
      if (!is_chk_pos(i)) begin
        c[i] = d[k];
        k++;
      end
    end
    return c;
  endfunction

  function automatic dword_t pick_data(cw_t c);
    dword_t d = '0;
    int     k = 0;
    for (int i = 1; i <= MAXPOS; i++) begin
      if (!is_chk_pos(i)) begin
        d[k] = c[i];
        k++;
      end
    end
    return d;
  endfunction

  function automatic logic [PW-1:0] syndrome(cw_t c);
    logic [PW-1:0] s = '0;
    for (int i = 1; i <= MAXPOS; i++) begin
      if (c[i]) s = s ^ PW'(i);
    end
    return s;
  endfunction
endpackage

// File: rtl/grp_ecc_enc.sv
module grp_ecc_enc
  import grp_ecc_pkg::*;
(
  input  dword_t data,
  output cw_t    code
);
  cw_t           raw;
  logic [PW-1:0] syn;
  logic [CW-1:1] hm;

  assign raw = place_data(data);
  assign syn = syndrome(raw);

  // fill each check position so the full syndrome becomes zero
  always_comb begin
    hm = raw[CW-1:1];
    for (int j = 0; j < PW; j++) begin
      hm[1 << j] = syn[j];
    end
  end

  assign code = {hm, ^hm};
endmodule

// File: rtl/grp_ecc_dec.sv
module grp_ecc_dec
  import grp_ecc_pkg::*;
(
  input  cw_t    code,
  output dword_t data,
  output logic   single,
  output logic   dbl
);
  logic [PW-1:0] syn;
  logic          ovr;
  cw_t           fixed;

  assign syn = syndrome(code);
  assign ovr = ^code;

  always_comb begin
    fixed  = code;
    single = 1'b0;
    dbl    = 1'b0;
    if (ovr) begin
      if (syn <= PW'(MAXPOS)) begin
        single     = 1'b1;
        fixed[syn] = ~code[syn];
      end else begin
        dbl = 1'b1;
      end
    end else if (syn != '0) begin
      dbl = 1'b1;
    end
  end

  assign data = pick_data(fixed);
endmodule

// File: rtl/grp_wear_cnt.sv
module grp_wear_cnt #(
  parameter int GW    = 6,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [GW-1:0]    idx,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int NGRP = 1 << GW;
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_all [NGRP];
  logic [CNT_W-1:0] cur;
  logic [CNT_W-1:0] nxt;

  for (genvar g = 0; g < NGRP; g++) begin : g_cnt
    logic [CNT_W-1:0] c_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        c_r <= '0;
      end else if (inc && idx == GW'(g) && c_r != MAXC) begin
        c_r <= c_r + 1'b1;
      end
    end
    assign cnt_all[g] = c_r;
  end

  assign cur = cnt_all[idx];
  assign nxt = (cur == MAXC) ? cur : cur + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (inc) cnt_q <= nxt;
  end
endmodule

// File: rtl/grp_ecc_mem.sv
module grp_ecc_mem
  import grp_ecc_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [AW-1:0]    req_addr,
  input  logic [7:0]       req_wdata,
  output logic             busy,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             wr_done,
  output logic [CNT_W-1:0] wr_cnt,
  output logic             err_corr,
  output logic             err_uncorr,
  output logic             arr_rd_en,
  output logic             arr_wr_en,
  output logic [AW-3:0]    arr_addr,
  output logic [38:0]      arr_wdata,
  input  logic [38:0]      arr_rdata
);
  localparam int GW    = AW - 2;
  localparam int LANES = DW / 8;

  st_t           st;
  logic [GW-1:0] grp_q;
  logic [1:0]    lane_q;
  logic          we_q;
  logic [7:0]    wdat_q;

  dword_t dec_data;
  dword_t merged;
  logic   dec_single;
  logic   dec_dbl;
  cw_t    enc_code;
  logic   cnt_inc;

  grp_ecc_dec dec_i (
    .code   (arr_rdata),
    .data   (dec_data),
    .single (dec_single),
    .dbl    (dec_dbl)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[8*b +: 8] = (lane_q == 2'(b)) ? wdat_q : dec_data[8*b +: 8];
  end

  grp_ecc_enc enc_i (
    .data (merged),
    .code (enc_code)
  );

  assign cnt_inc = (st == ST_CHECK) && we_q;

  grp_wear_cnt #(.GW(GW), .CNT_W(CNT_W)) wear_i (
    .clk   (clk),
    .rst   (rst),
    .inc   (cnt_inc),
    .idx   (grp_q),
    .cnt_q (wr_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      busy       <= 1'b0;
      grp_q      <= '0;
      lane_q     <= '0;
      we_q       <= 1'b0;
      wdat_q     <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      wr_done    <= 1'b0;
      err_corr   <= 1'b0;
      err_uncorr <= 1'b0;
      arr_rd_en  <= 1'b0;
      arr_wr_en  <= 1'b0;
      arr_addr   <= '0;
      arr_wdata  <= '0;
    end else begin
      rd_valid  <= 1'b0;
      wr_done   <= 1'b0;
      arr_rd_en <= 1'b0;
      arr_wr_en <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            grp_q     <= req_addr[AW-1:2];
            lane_q    <= req_addr[1:0];
            we_q      <= req_we;
            wdat_q    <= req_wdata;
            arr_addr  <= req_addr[AW-1:2];
            arr_rd_en <= 1'b1;
            busy      <= 1'b1;
            st        <= ST_FETCH;
          end
        end
        ST_FETCH: st <= ST_CHECK;
        ST_CHECK: begin
          busy <= 1'b0;
          st   <= ST_IDLE;
          if (dec_single) err_corr   <= 1'b1;
          if (dec_dbl)    err_uncorr <= 1'b1;
          if (we_q) begin
            arr_wr_en <= 1'b1;
            arr_wdata <= enc_code;
            wr_done   <= 1'b1;
          end else begin
            rd_valid <= 1'b1;
            rd_data  <= dec_data[8*lane_q +: 8];
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/grp_ecc_chk.sv
module grp_ecc_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic rd_valid,
  input logic wr_done,
  input logic err_corr,
  input logic err_uncorr,
  input logic arr_rd_en,
  input logic arr_wr_en
);
  // R6: a result pulse only ends an access that was running
  a_r6_result_after_busy: assert property (@(posedge clk) disable iff (rst)
    (rd_valid || wr_done) |-> $past(busy));

  // R6: busy falls together with exactly one result pulse
  a_r6_fall_one_result: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (rd_valid ^ wr_done));

  // R6: an idle request starts an access
  a_r6_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  // R9: one array read strobe per access
  a_r9_single_read: assert property (@(posedge clk) disable iff (rst)
    arr_rd_en |=> !arr_rd_en);

  // R9: array read and write never overlap
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(arr_rd_en && arr_wr_en));

  // R9: the array write belongs to a finished write access
  a_r9_write_at_done: assert property (@(posedge clk) disable iff (rst)
    arr_wr_en |-> (wr_done && !busy));

  // R4: corrected flag is sticky
  a_r4_corr_sticky: assert property (@(posedge clk) disable iff (rst)
    err_corr |=> err_corr);

  // R5: uncorrectable flag is sticky
  a_r5_uncorr_sticky: assert property (@(posedge clk) disable iff (rst)
    err_uncorr |=> err_uncorr);
endmodule

bind grp_ecc_mem grp_ecc_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .wr_done    (wr_done),
  .err_corr   (err_corr),
  .err_uncorr (err_uncorr),
  .arr_rd_en  (arr_rd_en),
  .arr_wr_en  (arr_wr_en)
);

// File: tb/grp_ecc_mem_tb_top.sv
module grp_ecc_mem_tb_top;
  localparam int AW    = 8;
  localparam int CNT_W = 3;
  localparam int GW    = AW - 2;
  localparam int NGRP  = 1 << GW;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_we = 1'b0;
  logic [AW-1:0]    req_addr = '0;
  logic [7:0]       req_wdata = '0;
  logic             busy, rd_valid, wr_done, err_corr, err_uncorr;
  logic [7:0]       rd_data;
  logic [CNT_W-1:0] wr_cnt;
  logic             arr_rd_en, arr_wr_en;
  logic [GW-1:0]    arr_addr;
  logic [38:0]      arr_wdata;
  logic [38:0]      arr_rdata = '0;

  always #5 clk = ~clk;

  grp_ecc_mem #(.AW(AW), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
    .wr_cnt(wr_cnt), .err_corr(err_corr), .err_uncorr(err_uncorr),
    .arr_rd_en(arr_rd_en), .arr_wr_en(arr_wr_en), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  // array model with bit-flip injection
  logic [38:0]   mem [NGRP];
  logic          inj_go = 1'b0;
  logic [GW-1:0] inj_addr = '0;
  logic [38:0]   inj_mask = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NGRP; i++) mem[i] <= '0;
    end else begin
      if (inj_go) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
      if (arr_wr_en) mem[arr_addr] <= arr_wdata;
    end
    if (arr_rd_en) arr_rdata <= mem[arr_addr];
  end

  typedef struct {
    bit         is_wr;
    bit         chk_data;
    logic [7:0] data;
    int         cnt;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] shadow [1 << AW];
  int         exp_cnt [NGRP];
  int         n_chk = 0;
  int         n_fail = 0;
  int         rd_pulses = 0;
  int         wr_pulses = 0;
  int         last_wr_addr = -1;
  bit         done = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops the scoreboard on every result pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (arr_rd_en) rd_pulses++;
      if (arr_wr_en) begin
        wr_pulses++;
        last_wr_addr = int'(arr_addr);
      end
      if (rd_valid || wr_done) begin
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected result pulse", {rd_valid, wr_done}, 0);
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          if (it.is_wr) begin
            check(wr_done && !rd_valid, {it.tag, " R6 write pulse"}, {rd_valid, wr_done}, 1);
            check(int'(wr_cnt) == it.cnt, {it.tag, " R7 wr_cnt"}, wr_cnt, it.cnt);
          end else begin
            check(rd_valid && !wr_done, {it.tag, " R6 read pulse"}, {rd_valid, wr_done}, 2);
            if (it.chk_data)
              check(rd_data == it.data, {it.tag, " rd_data"}, rd_data, it.data);
          end
        end
      end
    end
  end

  task automatic do_op(bit we, int addr, logic [7:0] d, string tag,
                       bit chk = 1, bit intrude = 0);
    exp_t it;
    int   g;
    int   rd0, wr0;
    g = addr >> 2;
    it.is_wr = we;
    it.chk_data = chk;
    it.tag = tag;
    it.cnt = 0;
    it.data = 8'h00;
    if (we) begin
      if (exp_cnt[g] < CMAX) exp_cnt[g]++;
      it.cnt = exp_cnt[g];
      shadow[addr] = d;
    end else begin
      it.data = shadow[addr];
    end
    exp_q.push_back(it);
    rd0 = rd_pulses;
    wr0 = wr_pulses;
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = AW'(addr);
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      // R6: request while busy, must be dropped
      req_valid = 1'b1;
      req_we    = 1'b1;
      req_addr  = AW'(8'h40);
      req_wdata = 8'hAA;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(rd_pulses - rd0 == 1, {tag, " R9 array reads"}, rd_pulses - rd0, 1);
    check(wr_pulses - wr0 == (we ? 1 : 0), {tag, " R9 array writes"},
          wr_pulses - wr0, we ? 1 : 0);
    if (we) check(last_wr_addr == g, {tag, " R3 array word index"}, last_wr_addr, g);
  endtask

  task automatic flip(int g, int b0, int b1 = -1);
    @(negedge clk);
    inj_go   = 1'b1;
    inj_addr = GW'(g);
    inj_mask = '0;
    inj_mask[b0] = 1'b1;
    if (b1 >= 0) inj_mask[b1] = 1'b1;
    @(negedge clk);
    inj_go = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) shadow[i] = 8'h00;
    for (int i = 0; i < NGRP; i++) exp_cnt[i] = 0;
    repeat (4) @(negedge clk);
    check({busy, rd_valid, wr_done, err_corr, err_uncorr, arr_rd_en, arr_wr_en} == 0,
          "R1 outputs in reset",
          {busy, rd_valid, wr_done, err_corr, err_uncorr, arr_rd_en, arr_wr_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({busy, rd_valid, wr_done, err_corr, err_uncorr, arr_rd_en, arr_wr_en} == 0,
          "R1 outputs after reset",
          {busy, rd_valid, wr_done, err_corr, err_uncorr, arr_rd_en, arr_wr_en}, 0);

    do_op(0, 8'h05, 8'h00, "R2 read of cleared byte");

    // R3: fill one group lane by lane, read neighbours back
    do_op(1, 8'h04, 8'h11, "R3 w04");
    do_op(1, 8'h05, 8'h22, "R3 w05");
    do_op(1, 8'h06, 8'h33, "R3 w06");
    do_op(1, 8'h07, 8'h44, "R3 w07");
    for (int a = 4; a < 8; a++) do_op(0, a, 8'h00, "R2 R3 group1 readback");
    do_op(1, 8'h06, 8'h5A, "R3 rewrite lane2");
    do_op(0, 8'h04, 8'h00, "R3 lane0 kept");
    do_op(0, 8'h05, 8'h00, "R3 lane1 kept");
    do_op(0, 8'h07, 8'h00, "R3 lane3 kept");
    do_op(0, 8'h06, 8'h00, "R2 lane2 new");

    // group 2 and top group
    for (int a = 8; a < 12; a++) do_op(1, a, 8'(8'hC0 + a), "R3 group2 fill");
    do_op(0, 8'h0A, 8'h00, "R2 group2 read");
    do_op(0, 8'h09, 8'h00, "R2 group2 read again");
    do_op(1, 8'h0B, 8'h7E, "R7 reads did not count");
    do_op(1, 8'hFF, 8'h96, "R3 last address write");
    do_op(0, 8'hFF, 8'h00, "R2 last address read");
    do_op(0, 8'hFC, 8'h00, "R3 last group lane0 kept");

    // R7: saturation on group 3
    for (int i = 0; i < CMAX + 2; i++) do_op(1, 12 + (i % 4), 8'(i * 17 + 3), "R7 saturate");
    do_op(0, 8'h0E, 8'h00, "R7 data after saturation");

    // R6: request slipped in while busy
    do_op(0, 8'h04, 8'h00, "R6 read with intruder", 1, 1);
    do_op(0, 8'h40, 8'h00, "R6 intruder address untouched");

    // R4: single flips in several positions
    check(err_corr == 0, "R4 err_corr clear before flips", err_corr, 0);
    flip(1, 0);
    do_op(0, 8'h05, 8'h00, "R4 overall parity flip");
    check(err_corr == 1, "R4 err_corr set", err_corr, 1);
    flip(3, 1);
    do_op(0, 8'h0D, 8'h00, "R4 check bit flip");
    flip(2, 38);
    do_op(0, 8'h0B, 8'h00, "R4 top data flip");
    flip(63, 3);
    do_op(0, 8'hFF, 8'h00, "R4 low data flip");
    check(err_uncorr == 0, "R4 singles not uncorrectable", err_uncorr, 0);

    // R8: write scrubs a latent flip
    do_op(1, 8'h14, 8'hA5, "R8 setup w14");
    do_op(1, 8'h15, 8'h5A, "R8 setup w15");
    flip(5, 12);
    do_op(1, 8'h16, 8'hC3, "R8 write over flip");
    flip(5, 25);
    do_op(0, 8'h14, 8'h00, "R8 lane0 after second flip");
    do_op(0, 8'h15, 8'h00, "R8 lane1 after second flip");
    do_op(0, 8'h16, 8'h00, "R8 lane2 after second flip");
    check(err_uncorr == 0, "R8 no double error after scrub", err_uncorr, 0);

    // R5: double flip (group 2 already holds a flip at bit 38)
    flip(2, 9);
    do_op(0, 8'h08, 8'h00, "R5 double error read", 0);
    check(err_uncorr == 1, "R5 err_uncorr set", err_uncorr, 1);
    do_op(0, 8'h04, 8'h00, "R5 clean read after double");
    check(err_uncorr == 1, "R5 err_uncorr sticky", err_uncorr, 1);
    check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);

    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R6 run did not finish actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end
endmodule